// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This block sits in a processor datapath and serves its saturating arithmetic instructions. It adds or subtracts two 32-bit signed operands, or takes a single operand on its own. It then clamps the value into a range whose bit width is chosen on every cycle, and the range can be either signed or unsigned. The arithmetic is carried at extended precision, so a 32-bit wrap never reaches the clamp. A per-result flag reports whether clamping took place.

A sticky bit collects that flag across every accepted operation. It stays set until an explicit clear. A build parameter chooses between a purely combinational result path and a registered one that answers one cycle after the input strobe.

Top module: `sat_addsub_unit`

## Requirements
- R1: In the two-operand modes the sum `op_a + op_b`, or the difference `op_a - op_b` when `sub` is 1, is formed from both operands sign-extended to at least 34 bits. A result that wraps in 32 bits is clamped, never wrapped.
- R2: The effective width W is `sat_width` for values 1 to 31. The value 0 selects W = 32.
- R3: With `op_mode` = 0 (signed two-operand), the value is clamped to [-2^(W-1), 2^(W-1)-1]. `out_result` is the clamped value sign-extended to 32 bits.
- R4: With `op_mode` = 1 (unsigned two-operand), the value is clamped to [0, 2^W-1]. `out_result` is zero-extended, and for W = 32 the upper bound is 0xFFFFFFFF.
- R5: With `op_mode` = 2 (signed single-operand), `op_a` alone is clamped to [-2^(W-1), 2^(W-1)-1]. `op_b` and `sub` have no effect on the result.
- R6: With `op_mode` = 3 (unsigned single-operand), `op_a` alone is clamped to [0, 2^W-1]. `op_b` and `sub` have no effect on the result.
- R7: `out_sat` is 1 exactly when the value lay outside the selected range. When it is 0, `out_result` equals the exact value, truncated to 32 bits.
- R8: `sticky_sat` is set at the clock edge that ends any cycle with `in_valid` high and a clamped result. It stays set while `sticky_clr` is low.
- R9: `sticky_clr` clears `sticky_sat` at the next edge. A clamped operation accepted in the same cycle sets it again.
- R10: With the output register enabled (default), `out_valid`, `out_result` and `out_sat` update at the edge after an `in_valid` cycle. `out_valid` is low after a cycle without `in_valid`, and `out_result` and `out_sat` then hold their last values.
- R11: After synchronous reset, `out_valid`, `out_result`, `out_sat` and `sticky_sat` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_mode | input | 2 | 0 signed add/sub, 1 unsigned add/sub, 2 signed saturate, 3 unsigned saturate |
| sub | input | 1 | 1 selects op_a minus op_b |
| sat_width | input | 5 | Saturation width, 0 means 32 |
| op_a | input | 32 | First signed operand |
| op_b | input | 32 | Second signed operand |
| sticky_clr | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Clamped result |
| out_sat | output | 1 | Clamping occurred for this result |
| sticky_sat | output | 1 | Accumulated clamping flag |

## Verification
The bench aims at sums that cross the 32-bit boundary, such as 0x7FFFFFFF + 1 and 0x80000000 - 1. A unit lacking the extended intermediate would wrap those values and leave the flag clear. It also tries width 1, width encoding 0 and unsigned width 32, where a bound formed with a shift by the full word would come out zero or inverted. Operands are driven to values exactly at each bound and one beyond it, which catches comparisons that are off by one. Further checks send garbage on `op_b` in the single-operand modes and issue a clear together with a clamped operation, so that leaks from an unused input and a wrong priority on the sticky bit both show up.

// File: rtl/satu_pkg.sv
package satu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned WSEL_W = 5;
    localparam int unsigned EXT_W  = DATA_W + 2;
    localparam int unsigned WEFF_W = WSEL_W + 1;

    typedef enum logic [1:0] {
        MODE_SADD = 2'd0,
        MODE_UADD = 2'd1,
        MODE_SSAT = 2'd2,
        MODE_USAT = 2'd3
    } sat_mode_e;

    typedef struct packed {
        logic              flag;
        logic [DATA_W-1:0] value;
    } sat_out_t;

    function automatic logic [WEFF_W-1:0] eff_width(input logic [WSEL_W-1:0] sel);
        logic [WEFF_W-1:0] w;
        if (sel == '0) w = WEFF_W'(DATA_W);
        else           w = {1'b0, sel};
        return w;
    endfunction

    function automatic logic mode_unsigned(input sat_mode_e m);
        return (m == MODE_UADD) || (m == MODE_USAT);
    endfunction

    function automatic logic mode_single(input sat_mode_e m);
        return (m == MODE_SSAT) || (m == MODE_USAT);
    endfunction

endpackage

// File: rtl/sat_extend.sv
module sat_extend
    import satu_pkg::*;
(
    input  sat_mode_e         mode,
    input  logic              sub,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [EXT_W-1:0]  ext
);
    localparam int unsigned PAD = EXT_W - DATA_W;

    logic [EXT_W-1:0] a_x;
    logic [EXT_W-1:0] b_x;

    always_comb begin
        a_x = {{PAD{op_a[DATA_W-1]}}, op_a};
        b_x = {{PAD{op_b[DATA_W-1]}}, op_b};
        if (mode_single(mode))
            ext = a_x;
        else if (sub)
            ext = a_x - b_x;
        else
            ext = a_x + b_x;
    end
endmodule

// File: rtl/sat_bounds.sv
module sat_bounds
    import satu_pkg::*;
(
    input  logic [WSEL_W-1:0] sat_width,
    input  logic              is_uns,
    output logic [EXT_W-1:0]  hi,
    output logic [EXT_W-1:0]  lo
);
    logic [WEFF_W-1:0] w;
    logic [EXT_W-1:0]  one;
    logic [EXT_W-1:0]  half_pow;
    logic [EXT_W-1:0]  full_pow;

    always_comb begin
        w        = eff_width(sat_width);
        one      = EXT_W'(1);
        half_pow = one << (w - WEFF_W'(1));
        full_pow = one << w;
        if (is_uns) begin
            hi = full_pow - one;
            lo = '0;
        end else begin
            hi = half_pow - one;
            lo = '0 - half_pow;
        end
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
    import satu_pkg::*;
(
    input  logic [EXT_W-1:0] ext,
    input  logic [EXT_W-1:0] hi,
    input  logic [EXT_W-1:0] lo,
    output sat_out_t         res
);
    logic above;
    logic below;

    always_comb begin
        above = $signed(ext) > $signed(hi);
        below = $signed(ext) < $signed(lo);
        res.flag = above | below;
        if (above)      res.value = hi[DATA_W-1:0];
        else if (below) res.value = lo[DATA_W-1:0];
        else            res.value = ext[DATA_W-1:0];
    end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_en,
    input  logic clr,
    output logic sticky
);
    always_ff @(posedge clk) begin
        if (rst) sticky <= 1'b0;
        else     sticky <= (sticky & ~clr) | set_en;
    end
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
    import satu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_mode,
    input  logic              sub,
    input  logic [WSEL_W-1:0] sat_width,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              sticky_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_sat,
    output logic              sticky_sat
);
    sat_mode_e        mode;
    logic [EXT_W-1:0] c_ext;
    logic [EXT_W-1:0] b_hi;
    logic [EXT_W-1:0] b_lo;
    sat_out_t         c_res;
    logic             c_flag;
    logic [DATA_W-1:0] c_result;

    assign mode     = sat_mode_e'(op_mode);
    assign c_flag   = c_res.flag;
    assign c_result = c_res.value;

    sat_extend u_extend (
        .mode (mode),
        .sub  (sub),
        .op_a (op_a),
        .op_b (op_b),
        .ext  (c_ext)
    );

    sat_bounds u_bounds (
        .sat_width (sat_width),
        .is_uns    (mode_unsigned(mode)),
        .hi        (b_hi),
        .lo        (b_lo)
    );

    sat_clamp u_clamp (
        .ext (c_ext),
        .hi  (b_hi),
        .lo  (b_lo),
        .res (c_res)
    );

    sat_sticky u_sticky (
        .clk    (clk),
        .rst    (rst),
        .set_en (in_valid & c_flag),
        .clr    (sticky_clr),
        .sticky (sticky_sat)
    );

    generate
        if (REG_OUT) begin : g_reg
            sat_out_t q_res;
            logic     q_valid;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_valid <= 1'b0;
                    q_res   <= '0;
                end else begin
                    q_valid <= in_valid;
                    if (in_valid) q_res <= c_res;
                end
            end
            assign out_valid  = q_valid;
            assign out_result = q_res.value;
            assign out_sat    = q_res.flag;
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_result = c_res.value;
            assign out_sat    = c_res.flag;
        end
    endgenerate
endmodule

// File: rtl/satu_checker.sv
module satu_checker
    import satu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        op_mode,
    input logic [WSEL_W-1:0] sat_width,
    input logic              sticky_clr,
    input logic              sticky_sat,
    input logic              out_valid,
    input logic              c_flag,
    input logic [DATA_W-1:0] c_result,
    input logic [DATA_W-1:0] c_ext_lo
);
    logic [5:0]        wk;
    logic [DATA_W-1:0] s_hi;
    logic [DATA_W-1:0] s_lo;
    logic [DATA_W-1:0] u_hi;

    always_comb begin
        wk   = (sat_width == '0) ? 6'd32 : {1'b0, sat_width};
        s_hi = (DATA_W'(1) << (wk - 6'd1)) - DATA_W'(1);
        s_lo = ~s_hi;
        u_hi = (DATA_W'(1) << wk) - DATA_W'(1);
    end

    // R3 and R5: signed clamp lands on a signed bound
    assert_sbound_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_mode[0] && c_flag) |-> (c_result == s_hi || c_result == s_lo));

    // R4 and R6: unsigned clamp lands on zero or the unsigned bound
    assert_ubound_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_mode[0] && c_flag) |-> (c_result == u_hi || c_result == '0));

    assert_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !c_flag) |-> (c_result == c_ext_lo));

    assert_sticky_set_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && c_flag) |=> sticky_sat);

    assert_sticky_clr_R9: assert property (@(posedge clk) disable iff (rst)
        (sticky_clr && !(in_valid && c_flag)) |=> !sticky_sat);

    generate
        if (REG_OUT) begin : g_lat
            assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
        end
    endgenerate
endmodule

bind sat_addsub_unit satu_checker #(.REG_OUT(REG_OUT)) u_satu_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_mode    (op_mode),
    .sat_width  (sat_width),
    .sticky_clr (sticky_clr),
    .sticky_sat (sticky_sat),
    .out_valid  (out_valid),
    .c_flag     (c_flag),
    .c_result   (c_result),
    .c_ext_lo   (c_ext[31:0])
);

// File: tb/test_sat_addsub_unit.sv
`timescale 1ns/1ps
module test_sat_addsub_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op_mode;
    logic        sub;
    logic [4:0]  sat_width;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic        sticky_clr;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_sat;
    logic        sticky_sat;

    int checks = 0;
    int fails  = 0;
    logic exp_sticky = 1'b0;
    logic [31:0] last_res;
    logic        last_sat;

    always #2.5 clk = ~clk;

    sat_addsub_unit i_sat_addsub_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_mode(op_mode),
        .sub(sub), .sat_width(sat_width), .op_a(op_a), .op_b(op_b),
        .sticky_clr(sticky_clr), .out_valid(out_valid),
        .out_result(out_result), .out_sat(out_sat), .sticky_sat(sticky_sat)
    );

    // Expected value from the requirement text: {flag, result}
    function automatic logic [32:0] model(input logic [1:0] m, input logic s,
                                          input logic [4:0] wsel,
                                          input logic [31:0] a, input logic [31:0] b);
        longint v, hi, lo, wv;
        logic f;
        wv = (wsel == 0) ? 32 : longint'(wsel);
        if (m >= 2)      v = longint'($signed(a));
        else if (s)      v = longint'($signed(a)) - longint'($signed(b));
        else             v = longint'($signed(a)) + longint'($signed(b));
        if (m[0]) begin
            hi = (longint'(1) << wv) - 1;
            lo = 0;
        end else begin
            hi = (longint'(1) << (wv - 1)) - 1;
            lo = -(longint'(1) << (wv - 1));
        end
        f = 1'b0;
        if (v > hi) begin v = hi; f = 1'b1; end
        else if (v < lo) begin v = lo; f = 1'b1; end
        return {f, v[31:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // drive at negedge, check at next negedge (one register stage)
    task automatic apply(input string req, input logic [1:0] m, input logic s,
                         input logic [4:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic clr);
        logic [32:0] e;
        e = model(m, s, w, a, b);
        in_valid = 1'b1; op_mode = m; sub = s; sat_width = w;
        op_a = a; op_b = b; sticky_clr = clr;
        exp_sticky = (exp_sticky & ~clr) | e[32];
        @(negedge clk);
        in_valid = 1'b0; sticky_clr = 1'b0;
        check({req, " result"}, out_result, e[31:0]);
        check("R7 flag", {31'd0, out_sat}, {31'd0, e[32]});
        check("R10 valid", {31'd0, out_valid}, 32'd1);
        check("R8 sticky", {31'd0, sticky_sat}, {31'd0, exp_sticky});
        last_res = e[31:0];
        last_sat = e[32];
    endtask

    function automatic logic [31:0] pick_operand();
        logic [31:0] k;
        k = $urandom_range(0, 3);
        case ($urandom_range(0, 3))
            0: return $urandom();
            1: return 32'($signed({1'b0, $urandom_range(0, 200)}) - 100);
            2: return 32'h7FFFFFFF - k;
            default: return 32'h80000000 + k;
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd20240611);
        rst = 1'b1; in_valid = 1'b0; op_mode = 2'd0; sub = 1'b0;
        sat_width = 5'd0; op_a = '0; op_b = '0; sticky_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 valid", {31'd0, out_valid}, 32'd0);
        check("R11 result", out_result, 32'd0);
        check("R11 flag", {31'd0, out_sat}, 32'd0);
        check("R11 sticky", {31'd0, sticky_sat}, 32'd0);

        // R1: 32-bit wrap cases, R2: width code 0 means 32
        apply("R1 add wrap", 2'd0, 1'b0, 5'd0, 32'h7FFFFFFF, 32'h1, 1'b0);
        check("R1 add wrap", out_result, 32'h7FFFFFFF);
        apply("R1 sub wrap", 2'd0, 1'b1, 5'd0, 32'h80000000, 32'h1, 1'b0);
        check("R1 sub wrap", out_result, 32'h80000000);
        apply("R2 w32 exact", 2'd0, 1'b1, 5'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
        check("R2 w32 exact", out_result, 32'h0);
        // R9: clear, then clear together with a clamping op
        apply("R9 clear", 2'd0, 1'b0, 5'd8, 32'd1, 32'd2, 1'b1);
        check("R9 cleared", {31'd0, sticky_sat}, 32'd0);
        apply("R9 clr+sat", 2'd0, 1'b0, 5'd8, 32'd127, 32'd1, 1'b1);
        check("R9 clr+sat", {31'd0, sticky_sat}, 32'd1);
        check("R3 w8 max", out_result, 32'h0000007F);
        apply("R3 w8 min", 2'd0, 1'b1, 5'd8, 32'hFFFFFF80, 32'd1, 1'b0);
        check("R3 w8 min", out_result, 32'hFFFFFF80);
        apply("R3 w1", 2'd0, 1'b0, 5'd1, 32'd0, 32'hFFFFFFFF, 1'b0);
        check("R3 w1 neg", out_result, 32'hFFFFFFFF);
        apply("R3 w1 pos", 2'd0, 1'b0, 5'd1, 32'd0, 32'd1, 1'b0);
        check("R3 w1 pos", out_result, 32'h0);
        // R4 unsigned width 32 and negative
        apply("R4 w32 big", 2'd1, 1'b0, 5'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
        check("R4 w32 no clamp", {31'd0, out_sat}, 32'd0);
        apply("R4 neg", 2'd1, 1'b1, 5'd16, 32'd3, 32'd4, 1'b1);
        check("R4 neg to zero", out_result, 32'd0);
        apply("R4 w16 top", 2'd1, 1'b0, 5'd16, 32'hFFFF, 32'd1, 1'b0);
        check("R4 w16 top", out_result, 32'h0000FFFF);
        // R5 and R6: op_b and sub have no effect
        apply("R5 ignore b", 2'd2, 1'b1, 5'd4, 32'd5, 32'h7FFFFFFF, 1'b0);
        check("R5 ignore b", out_result, 32'd5);
        apply("R5 clamp", 2'd2, 1'b0, 5'd4, 32'd8, 32'h80000000, 1'b0);
        check("R5 clamp", out_result, 32'd7);
        apply("R6 ignore b", 2'd3, 1'b1, 5'd4, 32'd15, 32'h12345678, 1'b0);
        check("R6 ignore b", out_result, 32'd15);
        apply("R6 clamp neg", 2'd3, 1'b0, 5'd4, 32'hFFFFFFFF, 32'd0, 1'b0);
        check("R6 clamp neg", out_result, 32'd0);

        // R10: idle cycle holds result, out_valid low
        op_a = 32'hDEADBEEF; op_b = 32'h13572468; op_mode = 2'd1;
        @(negedge clk);
        check("R10 idle valid", {31'd0, out_valid}, 32'd0);
        check("R10 hold result", out_result, last_res);
        check("R10 hold flag", {31'd0, out_sat}, {31'd0, last_sat});

        for (int i = 0; i < 3000; i++) begin
            logic [1:0] m;
            logic [4:0] w;
            m = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 3))
                0: w = 5'd0;
                1: w = 5'd1;
                default: w = 5'($urandom_range(0, 31));
            endcase
            apply(mode_req(m), m, 1'($urandom_range(0, 1)), w, pick_operand(),
                  pick_operand(), ($urandom_range(0, 15) == 0));
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                check("R10 idle valid", {31'd0, out_valid}, 32'd0);
                check("R10 hold result", out_result, last_res);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule